// File: doc/BRIEF.md
# Two-Port Contention-Arbitrated RAM

This block is a 2048-word by 8-bit storage array reached through two identical and independent ports, called left and right. Each port has an address, an active-low select, an active-low output enable, an active-low write strobe, write data, read data and a read-data drive flag. A port writes on every cycle in which its select and its write strobe are both low. It drives read data when its select and output enable are low and its write strobe is high. In every other case the drive flag is low and the read data is zero, which stands in for a high-impedance bus.

When both ports are selected at the same address, contention logic picks one owner. The port that arrived first owns the word. If both arrive in the same cycle, the left port owns it. The other port sees its active-low busy output go low, and any write it tries is held. Reads go ahead for both ports. A held write stays pending and completes on the first cycle after busy releases, provided the port still has select and write strobe low. The `SLAVE` parameter selects the variant. In master mode (`SLAVE`=0) the block arbitrates and drives the busy outputs. In slave mode (`SLAVE`=1) the block does not arbitrate, its busy outputs stay high, and each port's busy input blocks that port's writes.

Each port runs a mode machine with four states. PS_IDLE means the port is not selected. PS_READ means it is selected with the strobe high. PS_WRITE means a write is committing. PS_HELD means a write is blocked and pending. The transitions are: IDLE to READ or WRITE on select; IDLE or READ to HELD on a blocked write request; HELD to WRITE when busy releases (commit); HELD to READ when the strobe rises (withdraw); HELD to IDLE when select rises (abandon); WRITE to READ or HELD; and any state to IDLE on deselect. The master arbiter has three states. AR_FREE is the state with no match. From it, a new match goes to AR_LEFT_OWNS when the right port arrived last, or on a tie. It goes to AR_RIGHT_OWNS when the left port arrived last. Either owner state returns to AR_FREE in the same cycle the match ends.

Top module: `dual_port_contend_ram`

## Requirements
- R1: After reset, both busy outputs are high (1) and both drive flags are low (0).
- R2: Port inputs are captured at a clock edge. A write commits at the following edge when select and write strobe are low. A read with select and output enable low and strobe high shows the stored byte on that port's read data, with the drive flag at 1, two edges after the inputs are applied.
- R3: Every address from 0 to 2047 holds its own byte, including the lowest (0) and highest (2047) word.
- R4: The drive flag is 1 only for a read with select low, output enable low and strobe high. It is 0 during a write, even with output enable low, and 0 with output enable high or select high.
- R5: In master mode, when both ports are selected at the same address, the port that arrived later has its busy output at 0 and the earlier port keeps busy at 1. The busy value follows the captured inputs one edge after they are applied.
- R6: In master mode, if both ports reach a matching address in the same cycle, the left port wins (left busy 1, right busy 0), and only the left write is stored. The two busy outputs are never 0 together.
- R7: A write attempted while that port's busy is 0 does not change memory.
- R8: Busy returns to 1 in the first cycle whose captured inputs show different addresses or either select high.
- R9: A held write commits on the first cycle after busy releases if select and strobe are still low. If the strobe has risen by then, nothing is written.
- R10: A byte written on one port appears on the other port's read data one cycle after it commits, and the other port reads the old byte in the commit cycle.
- R11: In slave mode, a low busy input on a port blocks that port's write in the same cycle its inputs are captured. The busy outputs stay 1 and same-address accesses are not arbitrated.
- R12: Reads are never blocked by busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| l_addr | input | 11 | Left address |
| l_cs_n | input | 1 | Left select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_din | input | 8 | Left write data |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| l_dout | output | 8 | Left read data, zero when not driven |
| l_dout_en | output | 1 | Left read data drive flag |
| l_busy_out_n | output | 1 | Left busy in master mode, active low |
| r_addr | input | 11 | Right address |
| r_cs_n | input | 1 | Right select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_din | input | 8 | Right write data |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| r_dout | output | 8 | Right read data, zero when not driven |
| r_dout_en | output | 1 | Right read data drive flag |
| r_busy_out_n | output | 1 | Right busy in master mode, active low |

## Verification
The assertions check four rules on every cycle. Busy goes low only for a same-address match of two selected ports, and never on both ports at once. A port whose busy is low, or whose busy input was low in slave mode, never writes. The drive flag appears only two edges after a read request. The properties cannot see memory contents or arrival order. Those need the bench's scenarios: which port wins by arrival or by tie, that a held write lands after release or is dropped when withdrawn, the one-cycle port-to-port visibility, and the un-arbitrated slave behaviour.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_READ  = 2'd1,
        PS_WRITE = 2'd2,
        PS_HELD  = 2'd3
    } port_mode_e;

    typedef enum logic [1:0] {
        AR_FREE       = 2'd0,
        AR_LEFT_OWNS  = 2'd1,
        AR_RIGHT_OWNS = 2'd2
    } arb_owner_e;

endpackage

// File: rtl/dpr_port_side.sv
module dpr_port_side
    import dpr_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [DW-1:0] wdata,
    input  logic          blocked,
    output logic [AW-1:0] q_addr,
    output logic          q_sel,
    output logic          q_arrived,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          drive_en
);

    logic [AW-1:0] a_q;
    logic [AW-1:0] a_prev_q;
    logic          sel_q;
    logic          wreq_q;
    logic          oe_q;
    logic [DW-1:0] d_q;
    logic          drive_q;
    port_mode_e    mode_q;
    port_mode_e    mode_d;

    // capture of the port pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            a_prev_q <= '0;
            sel_q    <= 1'b0;
            wreq_q   <= 1'b0;
            oe_q     <= 1'b0;
            d_q      <= '0;
        end else begin
            a_q      <= addr;
            a_prev_q <= a_q;
            sel_q    <= ~cs_n;
            wreq_q   <= ~we_n;
            oe_q     <= ~oe_n;
            d_q      <= wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PS_IDLE;
        end else begin
            mode_q <= mode_d;
        end
    end

    // next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            PS_IDLE: begin
                if (sel_q) begin
                    if (!wreq_q)      mode_d = PS_READ;
                    else if (blocked) mode_d = PS_HELD;
                    else              mode_d = PS_WRITE;
                end
            end
            PS_READ: begin
                if (!sel_q)           mode_d = PS_IDLE;
                else if (wreq_q)      mode_d = blocked ? PS_HELD : PS_WRITE;
                else                  mode_d = PS_READ;
            end
            PS_WRITE: begin
                if (!sel_q)           mode_d = PS_IDLE;
                else if (!wreq_q)     mode_d = PS_READ;
                else if (blocked)     mode_d = PS_HELD;
                else                  mode_d = PS_WRITE;
            end
            PS_HELD: begin
                if (!sel_q)           mode_d = PS_IDLE;   // abandon
                else if (!wreq_q)     mode_d = PS_READ;   // withdraw
                else if (!blocked)    mode_d = PS_WRITE;  // commit pending
                else                  mode_d = PS_HELD;
            end
            default:                  mode_d = PS_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
        end else begin
            drive_q <= (mode_d == PS_READ) && oe_q;
        end
    end

    always_comb begin
        wr_en     = (mode_d == PS_WRITE);
        wr_data   = d_q;
        q_addr    = a_q;
        q_sel     = sel_q;
        q_arrived = sel_q && ((mode_q == PS_IDLE) || (a_q != a_prev_q));
        drive_en  = drive_q;
    end

endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int AW    = 11,
    parameter bit SLAVE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_l,
    input  logic          sel_r,
    input  logic [AW-1:0] addr_l,
    input  logic [AW-1:0] addr_r,
    input  logic          arr_l,
    input  logic          arr_r,
    input  logic          ext_l_n,
    input  logic          ext_r_n,
    output logic          block_l,
    output logic          block_r
);

    if (SLAVE) begin : g_slave
        logic ext_l_q;
        logic ext_r_q;
        logic unused_arb;

        assign unused_arb = ^{sel_l, sel_r, addr_l, addr_r, arr_l, arr_r};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ext_l_q <= 1'b1;
                ext_r_q <= 1'b1;
            end else begin
                ext_l_q <= ext_l_n;
                ext_r_q <= ext_r_n;
            end
        end

        assign block_l = ~ext_l_q;
        assign block_r = ~ext_r_q;
    end else begin : g_master
        arb_owner_e own_q;
        arb_owner_e own_d;
        logic       match;
        logic       unused_ext;

        assign unused_ext = ^{ext_l_n, ext_r_n};
        assign match      = sel_l && sel_r && (addr_l == addr_r);

        // state register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                own_q <= AR_FREE;
            end else begin
                own_q <= own_d;
            end
        end

        // next-state logic: owner of the current cycle
        always_comb begin
            own_d = own_q;
            unique case (own_q)
                AR_FREE: begin
                    if (!match)               own_d = AR_FREE;
                    else if (arr_l && !arr_r) own_d = AR_RIGHT_OWNS;
                    else                      own_d = AR_LEFT_OWNS;
                end
                AR_LEFT_OWNS: begin
                    if (!match)               own_d = AR_FREE;
                    else                      own_d = AR_LEFT_OWNS;
                end
                AR_RIGHT_OWNS: begin
                    if (!match)               own_d = AR_FREE;
                    else if (arr_l && arr_r)  own_d = AR_LEFT_OWNS;
                    else                      own_d = AR_RIGHT_OWNS;
                end
                default:                      own_d = AR_FREE;
            endcase
        end

        // outputs
        always_comb begin
            block_l = (own_d == AR_RIGHT_OWNS);
            block_r = (own_d == AR_LEFT_OWNS);
        end
    end

endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_l,
    input  logic [AW-1:0] a_l,
    input  logic [DW-1:0] wd_l,
    input  logic          we_r,
    input  logic [AW-1:0] a_r,
    input  logic [DW-1:0] wd_r,
    output logic [DW-1:0] rd_l,
    output logic [DW-1:0] rd_r
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_l_q;
    logic [DW-1:0] rd_r_q;

    // left is applied last so it takes precedence on an unarbitrated clash
    always_ff @(posedge clk) begin
        if (we_r) mem[a_r] <= wd_r;
        if (we_l) mem[a_l] <= wd_l;
        rd_l_q <= mem[a_l];
        rd_r_q <= mem[a_r];
    end

    assign rd_l = rd_l_q;
    assign rd_r = rd_r_q;

endmodule

// File: rtl/dual_port_contend_ram.sv
module dual_port_contend_ram #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    parameter bit SLAVE = 1'b0,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] l_addr,
    input  logic          l_cs_n,
    input  logic          l_oe_n,
    input  logic          l_we_n,
    input  logic [DW-1:0] l_din,
    input  logic          l_busy_in_n,
    output logic [DW-1:0] l_dout,
    output logic          l_dout_en,
    output logic          l_busy_out_n,
    input  logic [AW-1:0] r_addr,
    input  logic          r_cs_n,
    input  logic          r_oe_n,
    input  logic          r_we_n,
    input  logic [DW-1:0] r_din,
    input  logic          r_busy_in_n,
    output logic [DW-1:0] r_dout,
    output logic          r_dout_en,
    output logic          r_busy_out_n
);

    logic [AW-1:0] qa_l, qa_r;
    logic          sel_l, sel_r;
    logic          arr_l, arr_r;
    logic          wr_l, wr_r;
    logic [DW-1:0] wd_l, wd_r;
    logic [DW-1:0] rd_l, rd_r;
    logic          drv_l, drv_r;
    logic          block_l, block_r;

    dpr_port_side #(.AW(AW), .DW(DW)) u_left (
        .clk(clk), .rst_n(rst_n),
        .addr(l_addr), .cs_n(l_cs_n), .oe_n(l_oe_n), .we_n(l_we_n), .wdata(l_din),
        .blocked(block_l),
        .q_addr(qa_l), .q_sel(sel_l), .q_arrived(arr_l),
        .wr_en(wr_l), .wr_data(wd_l), .drive_en(drv_l)
    );

    dpr_port_side #(.AW(AW), .DW(DW)) u_right (
        .clk(clk), .rst_n(rst_n),
        .addr(r_addr), .cs_n(r_cs_n), .oe_n(r_oe_n), .we_n(r_we_n), .wdata(r_din),
        .blocked(block_r),
        .q_addr(qa_r), .q_sel(sel_r), .q_arrived(arr_r),
        .wr_en(wr_r), .wr_data(wd_r), .drive_en(drv_r)
    );

    dpr_arbiter #(.AW(AW), .SLAVE(SLAVE)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .sel_l(sel_l), .sel_r(sel_r),
        .addr_l(qa_l), .addr_r(qa_r),
        .arr_l(arr_l), .arr_r(arr_r),
        .ext_l_n(l_busy_in_n), .ext_r_n(r_busy_in_n),
        .block_l(block_l), .block_r(block_r)
    );

    dpr_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk),
        .we_l(wr_l), .a_l(qa_l), .wd_l(wd_l),
        .we_r(wr_r), .a_r(qa_r), .wd_r(wd_r),
        .rd_l(rd_l), .rd_r(rd_r)
    );

    assign l_dout_en    = drv_l;
    assign r_dout_en    = drv_r;
    assign l_dout       = drv_l ? rd_l : '0;
    assign r_dout       = drv_r ? rd_r : '0;
    assign l_busy_out_n = SLAVE ? 1'b1 : ~block_l;
    assign r_busy_out_n = SLAVE ? 1'b1 : ~block_r;

endmodule

// File: rtl/dpr_contend_chk.sv
module dpr_contend_chk #(
    parameter int AW    = 11,
    parameter bit SLAVE = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] l_addr,
    input logic [AW-1:0] r_addr,
    input logic          l_cs_n,
    input logic          r_cs_n,
    input logic          l_oe_n,
    input logic          l_we_n,
    input logic          l_busy_in_n,
    input logic          r_busy_in_n,
    input logic          l_busy_out_n,
    input logic          r_busy_out_n,
    input logic          l_dout_en,
    input logic          wr_l,
    input logic          wr_r
);

    // R4: drive flag only two edges after a read request
    p_drive_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
        l_dout_en |-> $past(!l_cs_n && !l_oe_n && l_we_n, 2));

    if (SLAVE) begin : g_slave_chk
        // R11: low busy input blocks that port's write
        p_ext_block_l_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(l_busy_in_n) |-> !wr_l);
        p_ext_block_r_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(r_busy_in_n) |-> !wr_r);
    end else begin : g_master_chk
        // R6: never two losers
        p_one_loser_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(!l_busy_out_n && !r_busy_out_n));
        // R5: busy only for a captured same-address match
        p_busy_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!l_busy_out_n || !r_busy_out_n) |->
                ($past(l_addr) == $past(r_addr) && !$past(l_cs_n) && !$past(r_cs_n)));
        // R8: deselect of either port releases busy
        p_release_on_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(l_cs_n) || $past(r_cs_n)) |-> (l_busy_out_n && r_busy_out_n));
        // R7: a busy port never writes
        p_busy_blocks_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !l_busy_out_n |-> !wr_l);
        p_busy_blocks_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !r_busy_out_n |-> !wr_r);
    end

endmodule

bind dual_port_contend_ram dpr_contend_chk #(.AW(AW), .SLAVE(SLAVE)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .r_addr(r_addr),
    .l_cs_n(l_cs_n), .r_cs_n(r_cs_n),
    .l_oe_n(l_oe_n), .l_we_n(l_we_n),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
    .l_dout_en(l_dout_en),
    .wr_l(wr_l), .wr_r(wr_r)
);

// File: tb/sim_dual_port_contend_ram.sv
`timescale 1ns/1ps
module sim_dual_port_contend_ram;

    localparam int K_BUSY_L = 0, K_BUSY_R = 1, K_EN_L = 2, K_EN_R = 3, K_DOUT_L = 4, K_DOUT_R = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [10:0] l_addr = '0, r_addr = '0;
    logic l_cs_n = 1'b1, l_oe_n = 1'b1, l_we_n = 1'b1;
    logic r_cs_n = 1'b1, r_oe_n = 1'b1, r_we_n = 1'b1;
    logic [7:0] l_din = '0, r_din = '0;
    logic bl_n = 1'b1, br_n = 1'b1;

    logic [7:0] m_ldo, m_rdo, s_ldo, s_rdo;
    logic m_len, m_ren, m_lb, m_rb, s_len, s_ren, s_lb, s_rb;

    dual_port_contend_ram #(.SLAVE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_din(l_din),
        .l_busy_in_n(1'b1), .l_dout(m_ldo), .l_dout_en(m_len), .l_busy_out_n(m_lb),
        .r_addr(r_addr), .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_din(r_din),
        .r_busy_in_n(1'b1), .r_dout(m_rdo), .r_dout_en(m_ren), .r_busy_out_n(m_rb)
    );

    dual_port_contend_ram #(.SLAVE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_din(l_din),
        .l_busy_in_n(bl_n), .l_dout(s_ldo), .l_dout_en(s_len), .l_busy_out_n(s_lb),
        .r_addr(r_addr), .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_din(r_din),
        .r_busy_in_n(br_n), .r_dout(s_rdo), .r_dout_en(s_ren), .r_busy_out_n(s_rb)
    );

    typedef struct {
        int         due;
        int         inst;
        int         kind;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] obs(int inst, int kind);
        logic [7:0] v;
        v = '0;
        if (inst == 0) begin
            case (kind)
                K_BUSY_L: v = {7'd0, m_lb};
                K_BUSY_R: v = {7'd0, m_rb};
                K_EN_L:   v = {7'd0, m_len};
                K_EN_R:   v = {7'd0, m_ren};
                K_DOUT_L: v = m_ldo;
                default:  v = m_rdo;
            endcase
        end else begin
            case (kind)
                K_BUSY_L: v = {7'd0, s_lb};
                K_BUSY_R: v = {7'd0, s_rb};
                K_EN_L:   v = {7'd0, s_len};
                K_EN_R:   v = {7'd0, s_ren};
                K_DOUT_L: v = s_ldo;
                default:  v = s_rdo;
            endcase
        end
        return v;
    endfunction

    // monitor: compares due items away from the active edge
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                logic [7:0] got;
                got = obs(q[i].inst, q[i].kind);
                checks++;
                if (got !== q[i].val) begin
                    failures++;
                    $display("FAIL %s inst=%0d kind=%0d cycle=%0d actual=%h expected=%h",
                             q[i].tag, q[i].inst, q[i].kind, cyc, got, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic expect_at(int d, int inst, int kind, logic [7:0] v, string tag);
        exp_t e;
        e.due = cyc + d; e.inst = inst; e.kind = kind; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drv_l(bit cs, bit we, bit oe, int a, logic [7:0] d);
        l_cs_n = cs; l_we_n = we; l_oe_n = oe; l_addr = a[10:0]; l_din = d;
    endtask

    task automatic drv_r(bit cs, bit we, bit oe, int a, logic [7:0] d);
        r_cs_n = cs; r_we_n = we; r_oe_n = oe; r_addr = a[10:0]; r_din = d;
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_both();
        drv_l(1, 1, 1, 0, 8'h00);
        drv_r(1, 1, 1, 0, 8'h00);
    endtask

    task automatic wr_left(int a, logic [7:0] d);
        drv_l(0, 0, 1, a, d); drv_r(1, 1, 1, 0, 8'h00); step();
        idle_both(); step();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired at cycle %0d actual=hung expected=finished", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        idle_both();
        step(3);
        rst_n = 1'b1;
        // R1: reset state
        expect_at(1, 0, K_BUSY_L, 8'h01, "R1");
        expect_at(1, 0, K_BUSY_R, 8'h01, "R1");
        expect_at(1, 0, K_EN_L,   8'h00, "R1");
        expect_at(1, 0, K_EN_R,   8'h00, "R1");
        step(2);

        // R2 / R4: write with output enable low, then read back
        drv_l(0, 0, 0, 5, 8'hA5);
        expect_at(2, 0, K_EN_L, 8'h00, "R4 write");
        step();
        drv_l(0, 1, 0, 5, 8'h00);
        expect_at(2, 0, K_EN_L,   8'h01, "R2");
        expect_at(2, 0, K_DOUT_L, 8'hA5, "R2");
        step();
        drv_l(0, 1, 1, 5, 8'h00);
        expect_at(2, 0, K_EN_L, 8'h00, "R4 oe high");
        step();
        drv_l(1, 1, 0, 5, 8'h00);
        expect_at(2, 0, K_EN_L, 8'h00, "R4 deselected");
        step();
        idle_both(); step(2);

        // R3: extreme addresses written on right, read on left
        drv_r(0, 0, 1, 2047, 8'h3C); step();
        drv_r(0, 0, 1, 0, 8'hC3); step();
        drv_r(1, 1, 1, 0, 8'h00);
        drv_l(0, 1, 0, 2047, 8'h00);
        expect_at(2, 0, K_DOUT_L, 8'h3C, "R3 top");
        step();
        drv_l(0, 1, 0, 0, 8'h00);
        expect_at(2, 0, K_DOUT_L, 8'hC3, "R3 bottom");
        step();
        idle_both(); step(2);

        // R5 / R7 / R12 / R9-withdraw: left reads first, right write later is held
        wr_left(10, 8'h11);
        drv_l(0, 1, 0, 10, 8'h00); step();
        drv_r(0, 0, 1, 10, 8'h99);
        expect_at(1, 0, K_BUSY_R, 8'h00, "R5 later loses");
        expect_at(1, 0, K_BUSY_L, 8'h01, "R5 earlier wins");
        expect_at(2, 0, K_DOUT_L, 8'h11, "R12 read while matched");
        step(2);
        drv_r(0, 1, 0, 10, 8'h00);
        expect_at(2, 0, K_EN_R,   8'h01, "R12 busy port reads");
        expect_at(2, 0, K_DOUT_R, 8'h11, "R7 held write withdrawn");
        step();
        idle_both(); step(2);

        // R8 / R9: release on deselect, pending write commits
        drv_l(0, 1, 0, 10, 8'h00); step();
        drv_r(0, 0, 1, 10, 8'h99);
        expect_at(1, 0, K_BUSY_R, 8'h00, "R5");
        step();
        drv_l(1, 1, 1, 0, 8'h00);
        expect_at(1, 0, K_BUSY_R, 8'h01, "R8 deselect");
        step();
        drv_r(0, 1, 0, 10, 8'h00);
        expect_at(2, 0, K_DOUT_R, 8'h99, "R9 pending commit");
        step();
        idle_both(); step(2);

        // R8: release on address change
        drv_l(0, 1, 0, 12, 8'h00); step();
        drv_r(0, 1, 0, 12, 8'h00);
        expect_at(1, 0, K_BUSY_R, 8'h00, "R5 read match");
        step();
        drv_l(0, 1, 0, 13, 8'h00);
        expect_at(1, 0, K_BUSY_R, 8'h01, "R8 address change");
        step();
        idle_both(); step(2);

        // R6: simultaneous arrival, left wins
        drv_l(0, 0, 1, 20, 8'hAA);
        drv_r(0, 0, 1, 20, 8'h55);
        expect_at(1, 0, K_BUSY_L, 8'h01, "R6 tie left");
        expect_at(1, 0, K_BUSY_R, 8'h00, "R6 tie right");
        step();
        idle_both(); step();
        drv_l(0, 1, 0, 20, 8'h00);
        expect_at(2, 0, K_DOUT_L, 8'hAA, "R6 stored");
        step();
        idle_both(); step(2);

        // R5 / R7: right first, left write blocked
        wr_left(30, 8'h30);
        drv_r(0, 1, 0, 30, 8'h00); step();
        drv_l(0, 0, 1, 30, 8'hEE);
        expect_at(1, 0, K_BUSY_L, 8'h00, "R5 left later");
        expect_at(1, 0, K_BUSY_R, 8'h01, "R5 right earlier");
        step();
        idle_both(); step();
        drv_l(0, 1, 0, 30, 8'h00);
        expect_at(2, 0, K_DOUT_L, 8'h30, "R7 blocked write");
        step();
        idle_both(); step(2);

        // R10: port-to-port visibility
        wr_left(40, 8'h01);
        drv_l(0, 0, 1, 40, 8'h77);
        drv_r(0, 1, 0, 40, 8'h00);
        expect_at(2, 0, K_DOUT_R, 8'h01, "R10 old in commit cycle");
        step();
        expect_at(2, 0, K_DOUT_R, 8'h77, "R10 new next cycle");
        step();
        idle_both(); step(2);

        // R11: slave, busy input blocks write
        wr_left(50, 8'h0F);
        bl_n = 1'b0;
        drv_l(0, 0, 1, 50, 8'h5A); step();
        bl_n = 1'b1;
        idle_both(); step();
        drv_l(0, 1, 0, 50, 8'h00);
        expect_at(2, 1, K_DOUT_L, 8'h0F, "R11 inhibited");
        step();
        idle_both(); step(2);

        // R11: slave, no arbitration and quiet busy outputs
        drv_l(0, 1, 0, 60, 8'h00); step();
        drv_r(0, 0, 1, 60, 8'h6B);
        expect_at(1, 1, K_BUSY_R, 8'h01, "R11 busy out high");
        expect_at(1, 1, K_BUSY_L, 8'h01, "R11 busy out high");
        step();
        idle_both(); step();
        drv_l(0, 1, 0, 60, 8'h00);
        expect_at(2, 1, K_DOUT_L, 8'h6B, "R11 no arbitration");
        step();
        idle_both(); step(2);

        // R9 / R11: write completes after busy input releases
        wr_left(52, 8'h00);
        bl_n = 1'b0;
        drv_l(0, 0, 1, 52, 8'hA1); step();
        bl_n = 1'b1; step();
        drv_l(0, 1, 0, 52, 8'h00);
        expect_at(2, 1, K_DOUT_L, 8'hA1, "R9 commit after release");
        step();
        idle_both(); step(4);

        foreach (q[i]) begin
            checks++;
            failures++;
            $display("FAIL %s never compared actual=none expected=%h", q[i].tag, q[i].val);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule